// File: doc/BRIEF.md
# Misaligned Access Exception Unit

This unit checks every data access from two address ports for natural alignment against the access size. An aligned access reaches memory: the read enable goes high for a load and the write enable goes high for a store, in the same cycle the access is presented. A misaligned access is blocked in that same cycle. The unit then raises a synchronous exception request on the following clock edge.

When it takes an exception, the unit loads three registers. The status register gets the alignment cause code. The fault address register gets the exact byte address that was presented. The return address register gets the address of the instruction that issued the access. The handler returns by pulsing a return strobe, which clears the request. Execution resumes at the captured return address, so the faulting instruction runs again, this time with a corrected address.

Size encoding is 2'b00 for a byte, 2'b01 for a halfword and 2'b10 for a word. The value 2'b11 is checked as a word.

Top module: `misalign_exc_unit`

## Requirements
- R1: A halfword access (size 2'b01) whose address has bit 0 set is misaligned. A halfword access with bit 0 clear is allowed through.
- R2: A word access (size 2'b10 or 2'b11) whose address has a low byte offset of 1, 2 or 3 is misaligned. Offset 0 is allowed through.
- R3: A byte access (size 2'b00) is never misaligned at any address and never raises the exception.
- R4: Loads (write flag 0) and stores (write flag 1) are checked in the same way. An allowed load drives only the read enable and an allowed store drives only the write enable.
- R5: For a misaligned access, both memory enables of that port are low in the cycle the access is presented.
- R6: On the edge after a fault, the exception request goes high and the status register reads 0x24.
- R7: The fault address register holds the unaligned byte address exactly as presented, not rounded down.
- R8: The return address register holds the instruction address that was presented with the faulting access, so execution resumes at that instruction.
- R9: Port 0 and port 1 are both checked. When both fault in the same cycle, port 0's address is captured.
- R10: While the request is pending, new faults are still blocked but do not change any register. A fault in the same cycle as the return strobe is also ignored.
- R11: A return strobe clears the request on the next edge, and the captured registers keep their values.
- R12: After reset, the request, status, fault address and return address are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| p0_vld | input | 1 | Port 0 access valid |
| p0_wr | input | 1 | Port 0 store (1) or load (0) |
| p0_size | input | 2 | Port 0 access size |
| p0_addr | input | 32 | Port 0 byte address |
| p1_vld | input | 1 | Port 1 access valid |
| p1_wr | input | 1 | Port 1 store (1) or load (0) |
| p1_size | input | 2 | Port 1 access size |
| p1_addr | input | 32 | Port 1 byte address |
| insn_addr | input | 32 | Address of the instruction issuing this cycle |
| exc_ret | input | 1 | Return-from-exception strobe |
| p0_rd_en | output | 1 | Port 0 memory read enable |
| p0_wr_en | output | 1 | Port 0 memory write enable |
| p1_rd_en | output | 1 | Port 1 memory read enable |
| p1_wr_en | output | 1 | Port 1 memory write enable |
| exc_req | output | 1 | Exception request pending |
| exc_status | output | 8 | Cause and status register |
| fault_addr | output | 32 | Captured faulting byte address |
| ret_addr | output | 32 | Captured faulting instruction address |

## Verification
The assertions assume that the access fields and the instruction address are stable and known whenever a valid strobe is high. They also assume that the return strobe only arrives while a request is pending or is otherwise harmless. The stimulus changes inputs only on the falling clock edge, and it returns every field to an idle, known value after each access. It pulses the return strobe only to end a pending exception. The one exception is a deliberate case where the strobe coincides with a new fault.

// File: rtl/maa_pkg.sv
package maa_pkg;
    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_RSVD = 2'b11
    } acc_size_e;

    localparam int STAT_W = 8;
    localparam logic [STAT_W-1:0] CAUSE_ALIGN = 8'h24;
endpackage

// File: rtl/maa_port_check.sv
module maa_port_check #(
    parameter int AW = 32
) (
    input  logic          vld,
    input  logic          wr,
    input  logic [1:0]    size,
    input  logic [AW-1:0] addr,
    output logic          rd_en,
    output logic          wr_en,
    output logic          fault
);
    import maa_pkg::*;

    logic mis;

    always_comb begin
        case (acc_size_e'(size))
            SZ_BYTE: mis = 1'b0;
            SZ_HALF: mis = addr[0];
            default: mis = |addr[1:0];
        endcase
        fault = vld & mis;
        rd_en = vld & ~wr & ~mis;
        wr_en = vld & wr & ~mis;
    end
endmodule

// File: rtl/maa_fault_capture.sv
module maa_fault_capture #(
    parameter int AW = 32,
    parameter int NP = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NP-1:0]              fault,
    input  logic [NP-1:0][AW-1:0]      addr,
    input  logic [AW-1:0]              insn_addr,
    input  logic                       exc_ret,
    output logic                       pend,
    output logic [maa_pkg::STAT_W-1:0] status,
    output logic [AW-1:0]              faddr,
    output logic [AW-1:0]              raddr
);
    import maa_pkg::*;

    typedef struct packed {
        logic              pend;
        logic [STAT_W-1:0] status;
        logic [AW-1:0]     faddr;
        logic [AW-1:0]     raddr;
    } cap_t;

    cap_t st_d, st_q;
    logic [AW-1:0] sel_addr_d;
    logic any_fault_d;

    always_comb begin
        sel_addr_d  = '0;
        any_fault_d = |fault;
        // lowest index has priority: walk downwards, last hit wins
        for (int i = NP - 1; i >= 0; i--) begin
            if (fault[i]) sel_addr_d = addr[i];
        end
        st_d = st_q;
        if (st_q.pend) begin
            if (exc_ret) st_d.pend = 1'b0;
        end else if (any_fault_d) begin
            st_d.pend   = 1'b1;
            st_d.status = CAUSE_ALIGN;
            st_d.faddr  = sel_addr_d;
            st_d.raddr  = insn_addr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend   = st_q.pend;
    assign status = st_q.status;
    assign faddr  = st_q.faddr;
    assign raddr  = st_q.raddr;

    // R6
    cause_on_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend) |-> status == CAUSE_ALIGN);

    // R10
    hold_regs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pend |=> $stable(faddr) && $stable(raddr) && $stable(status));

    // R11
    pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pend && !exc_ret |=> pend);

    // R8
    ret_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pend && (|fault) |=> raddr == $past(insn_addr));
endmodule

// File: rtl/misalign_exc_unit.sv
module misalign_exc_unit #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          p0_vld,
    input  logic          p0_wr,
    input  logic [1:0]    p0_size,
    input  logic [AW-1:0] p0_addr,
    input  logic          p1_vld,
    input  logic          p1_wr,
    input  logic [1:0]    p1_size,
    input  logic [AW-1:0] p1_addr,
    input  logic [AW-1:0] insn_addr,
    input  logic          exc_ret,
    output logic          p0_rd_en,
    output logic          p0_wr_en,
    output logic          p1_rd_en,
    output logic          p1_wr_en,
    output logic          exc_req,
    output logic [7:0]    exc_status,
    output logic [AW-1:0] fault_addr,
    output logic [AW-1:0] ret_addr
);
    import maa_pkg::*;

    localparam int NP = 2;

    logic [NP-1:0]         vld_v, wr_v, rd_en_v, wr_en_v, fault_v;
    logic [NP-1:0][1:0]    size_v;
    logic [NP-1:0][AW-1:0] addr_v;

    assign vld_v  = {p1_vld, p0_vld};
    assign wr_v   = {p1_wr, p0_wr};
    assign size_v = {p1_size, p0_size};
    assign addr_v = {p1_addr, p0_addr};

    for (genvar g = 0; g < NP; g++) begin : g_port
        maa_port_check #(.AW(AW)) u_chk (
            .vld   (vld_v[g]),
            .wr    (wr_v[g]),
            .size  (size_v[g]),
            .addr  (addr_v[g]),
            .rd_en (rd_en_v[g]),
            .wr_en (wr_en_v[g]),
            .fault (fault_v[g])
        );
    end

    assign p0_rd_en = rd_en_v[0];
    assign p0_wr_en = wr_en_v[0];
    assign p1_rd_en = rd_en_v[1];
    assign p1_wr_en = wr_en_v[1];

    maa_fault_capture #(.AW(AW), .NP(NP)) u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .fault     (fault_v),
        .addr      (addr_v),
        .insn_addr (insn_addr),
        .exc_ret   (exc_ret),
        .pend      (exc_req),
        .status    (exc_status),
        .faddr     (fault_addr),
        .raddr     (ret_addr)
    );

    // R5
    half_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        p0_vld && p0_size == 2'b01 && p0_addr[0] |-> !p0_rd_en && !p0_wr_en);

    // R3
    byte_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        p0_vld && p0_size == 2'b00 && !p0_wr |-> p0_rd_en);

    // R9
    both_pick_p0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !exc_req && p0_vld && p0_size == 2'b10 && (|p0_addr[1:0])
        |=> exc_req && fault_addr == $past(p0_addr));
endmodule

// File: tb/misalign_exc_unit_test.sv
module misalign_exc_unit_test;
    logic        clk = 0, rst_n = 0;
    logic        p0_vld = 0, p0_wr = 0, p1_vld = 0, p1_wr = 0, exc_ret = 0;
    logic [1:0]  p0_size = 0, p1_size = 0;
    logic [31:0] p0_addr = 0, p1_addr = 0, insn_addr = 0;
    logic        p0_rd_en, p0_wr_en, p1_rd_en, p1_wr_en, exc_req;
    logic [7:0]  exc_status;
    logic [31:0] fault_addr, ret_addr;
    int total = 0, bad = 0;

    always #4 clk = ~clk;

    misalign_exc_unit uut (.*);

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(int port, logic w, logic [1:0] sz, logic [31:0] a, logic [31:0] ia);
        @(negedge clk);
        insn_addr = ia;
        if (port == 0) begin p0_vld = 1; p0_wr = w; p0_size = sz; p0_addr = a; end
        else begin p1_vld = 1; p1_wr = w; p1_size = sz; p1_addr = a; end
        #1;
    endtask

    task automatic idle_step();
        @(negedge clk);
        p0_vld = 0; p1_vld = 0; p0_wr = 0; p1_wr = 0; exc_ret = 0;
        p0_addr = 0; p1_addr = 0; p0_size = 0; p1_size = 0; insn_addr = 0;
        #1;
    endtask

    task automatic do_return();
        @(negedge clk); exc_ret = 1;
        idle_step();
        chk("R11 request cleared", exc_req, 0);
    endtask

    task automatic fault_case(string req, int port, logic w, logic [1:0] sz,
                              logic [31:0] a, logic [31:0] ia);
        drive(port, w, sz, a, ia);
        if (port == 0) chk({req, " R5 p0 enables"}, {p0_rd_en, p0_wr_en}, 0);
        else           chk({req, " R5 p1 enables"}, {p1_rd_en, p1_wr_en}, 0);
        idle_step();
        chk({req, " R6 request"}, exc_req, 1);
        chk({req, " R6 status"}, exc_status, 8'h24);
        chk({req, " R7 fault addr"}, fault_addr, a);
        chk({req, " R8 return addr"}, ret_addr, ia);
        do_return();
        chk({req, " R11 regs kept"}, fault_addr, a);
    endtask

    task automatic pass_case(string req, int port, logic w, logic [1:0] sz, logic [31:0] a);
        drive(port, w, sz, a, 32'h300);
        if (port == 0) chk({req, " R4 p0 enables"}, {p0_rd_en, p0_wr_en}, {~w, w});
        else           chk({req, " R4 p1 enables"}, {p1_rd_en, p1_wr_en}, {~w, w});
        idle_step();
        chk({req, " no request"}, exc_req, 0);
    endtask

    task automatic t_reset();
        #1;
        chk("R12 reset req", exc_req, 0);
        chk("R12 reset status", exc_status, 0);
        chk("R12 reset fault", fault_addr, 0);
        chk("R12 reset ret", ret_addr, 0);
        @(negedge clk); rst_n = 1;
    endtask

    task automatic t_half();
        fault_case("R1 half load", 0, 0, 2'b01, 32'h1001, 32'h200);
        fault_case("R1 half store", 0, 1, 2'b01, 32'h1003, 32'h204);
        pass_case("R1 half aligned", 0, 0, 2'b01, 32'h1002);
    endtask

    task automatic t_word();
        fault_case("R2 off1", 0, 1, 2'b10, 32'h1001, 32'h210);
        fault_case("R2 off2", 0, 0, 2'b10, 32'h1002, 32'h214);
        fault_case("R2 off3", 0, 1, 2'b10, 32'h1003, 32'h218);
        fault_case("R2 rsvd size", 0, 0, 2'b11, 32'h1002, 32'h21c);
        pass_case("R2 word aligned", 0, 1, 2'b10, 32'h1000);
    endtask

    task automatic t_byte();
        for (int i = 0; i < 4; i++) begin
            pass_case("R3 byte load", 0, 0, 2'b00, 32'h1000 + i);
            pass_case("R3 byte store", 1, 1, 2'b00, 32'h1000 + i);
        end
    endtask

    task automatic t_port1();
        fault_case("R9 p1 half", 1, 0, 2'b01, 32'h2001, 32'h220);
        fault_case("R9 p1 word", 1, 1, 2'b10, 32'h2003, 32'h224);
        pass_case("R4 p1 load", 1, 0, 2'b10, 32'h2004);
    endtask

    task automatic t_both();
        @(negedge clk);
        insn_addr = 32'h230;
        p0_vld = 1; p0_size = 2'b10; p0_addr = 32'h3002;
        p1_vld = 1; p1_size = 2'b01; p1_addr = 32'h4001; p1_wr = 1;
        idle_step();
        chk("R9 both port0 wins", fault_addr, 32'h3002);
        do_return();
    endtask

    task automatic t_pending();
        drive(0, 0, 2'b10, 32'h5001, 32'h240);
        idle_step();
        drive(1, 1, 2'b01, 32'h6001, 32'h244);
        chk("R10 blocked while pending", p1_wr_en, 0);
        idle_step();
        chk("R10 fault kept", fault_addr, 32'h5001);
        chk("R10 ret kept", ret_addr, 32'h240);
        @(negedge clk);
        exc_ret = 1; insn_addr = 32'h248;
        p0_vld = 1; p0_size = 2'b01; p0_addr = 32'h7001;
        idle_step();
        chk("R10 fault with return ignored", exc_req, 0);
        chk("R10 addr unchanged", fault_addr, 32'h5001);
        pass_case("R11 retry aligned", 0, 0, 2'b10, 32'h5000);
    endtask

    initial begin
        repeat (2) @(posedge clk);
        t_reset();
        t_half();
        t_word();
        t_byte();
        t_port1();
        t_both();
        t_pending();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule